// File: doc/BRIEF.md
# Audio Converter Reset Release Sequencer

This block orders the events that follow the release of the system reset in an audio converter core. It runs on the fast master clock. It brings the asynchronous active-low system reset into that clock domain and watches the frame clock for rising edges. It counts frame periods from the first edge after release. From that count it schedules three things: a clear of the internal data memory, a gate on the generators that make the frame and bit clocks when the core is the clock master, and the point where ADC output words stop being forced to zero and are marked valid.

Master or slave operation is chosen by a mode input. The mode is captured only while the system reset is held. In master mode the frame counter starts on the first frame-clock rising edge after release. In slave mode it starts two frame periods after release, which is taken as the second rising edge. The memory clear always starts on the first edge and lasts eight frame periods. ADC output is marked valid a fixed 516 frames after the counter starts. Asserting the system reset again at any moment abandons the sequence.

Top module: `codec_rst_seq`

## Requirements
- R1: While the system reset input is low, `adc_zero_o` is 1 and `mem_busy_o`, `mem_clr_o`, `adc_valid_o` and `clk_gen_en_o` are 0.
- R2: If the system reset input goes low while a sequence is in progress, all outputs reach the values of R1 at the first master-clock edge after the fall.
- R3: After release in master mode (`master_mode_i` = 1 while in reset), `clk_gen_en_o` goes to 1 and stays there. In slave mode it stays 0.
- R4: `mem_clr_o` pulses for exactly one master-clock cycle on the first frame-clock rising edge after release. It pulses once per release.
- R5: `mem_busy_o` rises with the first frame-clock rising edge after release and falls on rising edge number CLR_FRAMES+1 (default 8 frames of busy).
- R6: In master mode, `adc_valid_o` rises on frame-clock rising edge number 1+VALID_FRAMES after release (default 517). It is 0 before that edge.
- R7: In slave mode, `adc_valid_o` rises on rising edge number SLAVE_DELAY+VALID_FRAMES after release (default 2+516 = 518). It is 0 before that edge.
- R8: `adc_valid_o` is never 1 while `mem_busy_o` is 1. Once it is 1, it stays 1 until the system reset is asserted again.
- R9: Changes on `master_mode_i` while the system reset is high have no effect on `clk_gen_en_o` or on the timing of R6 and R7.
- R10: A frame clock that is already high at release does not count as a rising edge. Only a low-to-high transition seen after release starts the sequence.
- R11: `adc_zero_o` goes to 0 once the synchronized system reset is released.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Block power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low, asynchronous to clk_i |
| master_mode_i | input | 1 | 1 = master (frame clock generated), 0 = slave |
| lrclk_i | input | 1 | Frame clock in use, generated or received |
| clk_gen_en_o | output | 1 | Enable for the frame and bit clock generators |
| mem_clr_o | output | 1 | One-cycle strobe that starts the data-memory clear |
| mem_busy_o | output | 1 | High for the memory-clear window |
| adc_zero_o | output | 1 | Forces ADC output words to all zeros |
| adc_valid_o | output | 1 | ADC output is valid |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an eight-frame clear, a 516-frame validity delay and a slave start delay of two frames. The frame period in the bench is 12 master clocks, so a full release sequence takes about 6,300 cycles. This makes the real 517th and 518th edges reachable several times in one run, in both modes. It also leaves room for aborts inside the clear window and inside the long count, and for a frame clock that is already high when the reset is released.

// File: rtl/codec_rst_pkg.sv
package codec_rst_pkg;

  typedef enum logic [2:0] {
    PH_HOLD  = 3'd0,
    PH_ARMED = 3'd1,
    PH_CLEAR = 3'd2,
    PH_COUNT = 3'd3,
    PH_LIVE  = 3'd4
  } seq_phase_e;

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
  parameter int unsigned STAGES = 2,
  parameter bit          CLR_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stage_d = d_i;
    end else begin : g_many
      always_comb stage_d = {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= {STAGES{CLR_VAL}};
    else          stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/frame_edge_det.sv
module frame_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrclk_i,
  output logic rise_o
);

  logic lr_sync;
  logic lr_prev_q;

  rst_sync_chain #(
    .STAGES  (STAGES),
    .CLR_VAL (1'b0)
  ) u_lr_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .d_i     (lrclk_i),
    .q_o     (lr_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lr_prev_q <= 1'b0;
    else         lr_prev_q <= lr_sync;
  end

  assign rise_o = lr_sync & ~lr_prev_q;

  // R10
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/rst_phase_fsm.sv
module rst_phase_fsm
  import codec_rst_pkg::*;
#(
  parameter int unsigned CLR_FRAMES   = 8,
  parameter int unsigned VALID_FRAMES = 516,
  parameter int unsigned SLAVE_DELAY  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic master_mode_i,
  input  logic rise_i,
  output logic clk_gen_en_o,
  output logic mem_clr_o,
  output logic mem_busy_o,
  output logic adc_zero_o,
  output logic adc_valid_o
);

  localparam int unsigned MasterTgt = 1 + VALID_FRAMES;
  localparam int unsigned SlaveTgt  = SLAVE_DELAY + VALID_FRAMES;
  localparam int unsigned MaxEdge   = (MasterTgt > SlaveTgt) ? MasterTgt : SlaveTgt;
  localparam int unsigned CntW      = $clog2(MaxEdge + 1);

  seq_phase_e      phase_q, phase_d;
  logic [CntW-1:0] cnt_q, cnt_d;
  logic [CntW-1:0] cnt_inc;
  logic [CntW-1:0] target;
  logic            mode_q, mode_d;
  logic            clr_q, clr_d;
  logic            gen_q, gen_d;
  logic            zero_q, zero_d;

  assign cnt_inc = cnt_q + CntW'(1);
  assign target  = mode_q ? CntW'(MasterTgt) : CntW'(SlaveTgt);

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    clr_d   = 1'b0;
    gen_d   = run_i & mode_q;
    zero_d  = ~run_i;
    if (!run_i) begin
      phase_d = PH_HOLD;
      cnt_d   = '0;
      mode_d  = master_mode_i;
    end else begin
      if (rise_i && (phase_q != PH_HOLD) && (phase_q != PH_LIVE)) begin
        cnt_d = cnt_inc;
      end
      unique case (phase_q)
        PH_HOLD:  phase_d = PH_ARMED;
        PH_ARMED: begin
          if (rise_i) begin
            phase_d = PH_CLEAR;
            clr_d   = 1'b1;
          end
        end
        PH_CLEAR: begin
          if (rise_i && (cnt_q == CntW'(CLR_FRAMES))) begin
            phase_d = (cnt_inc >= target) ? PH_LIVE : PH_COUNT;
          end
        end
        PH_COUNT: begin
          if (rise_i && (cnt_inc >= target)) phase_d = PH_LIVE;
        end
        PH_LIVE:  phase_d = PH_LIVE;
        default:  phase_d = PH_HOLD;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      clr_q   <= 1'b0;
      gen_q   <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      clr_q   <= clr_d;
      gen_q   <= gen_d;
      zero_q  <= zero_d;
    end
  end

  assign clk_gen_en_o = gen_q;
  assign mem_clr_o    = clr_q;
  assign mem_busy_o   = (phase_q == PH_CLEAR);
  assign adc_valid_o  = (phase_q == PH_LIVE);
  assign adc_zero_o   = zero_q;

  // R8
  busy_valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_busy_o && adc_valid_o));

  // R8
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_valid_o && run_i) |=> adc_valid_o);

  // R4
  clr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_clr_o |=> !mem_clr_o);

  // R2
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!mem_busy_o && !adc_valid_o && adc_zero_o && !clk_gen_en_o));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(mode_q));

  // R5
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_busy_o) |-> mem_clr_o);

endmodule

// File: rtl/codec_rst_seq.sv
module codec_rst_seq #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned CLR_FRAMES   = 8,
  parameter int unsigned VALID_FRAMES = 516,
  parameter int unsigned SLAVE_DELAY  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_ni,
  input  logic master_mode_i,
  input  logic lrclk_i,
  output logic clk_gen_en_o,
  output logic mem_clr_o,
  output logic mem_busy_o,
  output logic adc_zero_o,
  output logic adc_valid_o
);

  logic sys_arst_n;
  logic run;
  logic rise;

  assign sys_arst_n = rst_ni & sys_rst_ni;

  rst_sync_chain #(
    .STAGES  (SYNC_STAGES),
    .CLR_VAL (1'b0)
  ) u_sys_sync (
    .clk_i   (clk_i),
    .arst_ni (sys_arst_n),
    .d_i     (1'b1),
    .q_o     (run)
  );

  frame_edge_det #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lrclk_i (lrclk_i),
    .rise_o  (rise)
  );

  rst_phase_fsm #(
    .CLR_FRAMES   (CLR_FRAMES),
    .VALID_FRAMES (VALID_FRAMES),
    .SLAVE_DELAY  (SLAVE_DELAY)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run),
    .master_mode_i (master_mode_i),
    .rise_i        (rise),
    .clk_gen_en_o  (clk_gen_en_o),
    .mem_clr_o     (mem_clr_o),
    .mem_busy_o    (mem_busy_o),
    .adc_zero_o    (adc_zero_o),
    .adc_valid_o   (adc_valid_o)
  );

  // R1
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_ni |=> (!mem_clr_o && !mem_busy_o && !adc_valid_o && adc_zero_o));

  // R11
  run_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> $past(sys_rst_ni));

endmodule

// File: tb/codec_rst_seq_tb.sv
module codec_rst_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLR_FRAMES = 8;
  localparam int VALID_FRAMES = 516;
  localparam int SLAVE_DELAY = 2;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n;
  logic sys_rst_n;
  logic master_mode;
  logic lrclk;
  logic gen_en, mem_clr, mem_busy, adc_zero, adc_valid;

  int n_checks = 0;
  int n_fail = 0;
  int clr_seen = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_rst_seq dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sys_rst_ni    (sys_rst_n),
    .master_mode_i (master_mode),
    .lrclk_i       (lrclk),
    .clk_gen_en_o  (gen_en),
    .mem_clr_o     (mem_clr),
    .mem_busy_o    (mem_busy),
    .adc_zero_o    (adc_zero),
    .adc_valid_o   (adc_valid)
  );

  always @(negedge clk) if (mem_clr) clr_seen++;

  function automatic int exp_busy(int k);
    return (k >= 1 && k <= CLR_FRAMES) ? 1 : 0;
  endfunction

  function automatic int exp_valid(bit mode, int k);
    int s = mode ? 1 : SLAVE_DELAY;
    return (k >= s + VALID_FRAMES) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reset_state(string req);
    chk({req, " zero"}, int'(adc_zero), 1);
    chk({req, " busy"}, int'(mem_busy), 0);
    chk({req, " valid"}, int'(adc_valid), 0);
    chk({req, " clr"}, int'(mem_clr), 0);
    chk({req, " gen"}, int'(gen_en), 0);
  endtask

  // abort_at = 0: run to completion
  task automatic trial(bit mode, int abort_at, bit lr_high);
    int limit;
    @(negedge clk);
    sys_rst_n = 1'b0;
    master_mode = mode;
    lrclk = lr_high;
    repeat (4) @(negedge clk);
    chk_reset_state("R1");
    clr_seen = 0;
    sys_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 zero released", int'(adc_zero), 0);
    master_mode = ~mode; // R9 stimulus: ignored while running
    repeat (2) @(negedge clk);
    chk("R3 gen enable", int'(gen_en), int'(mode));
    if (lr_high) begin
      chk("R10 no edge busy", int'(mem_busy), 0);
      chk("R10 no edge clr", clr_seen, 0);
      lrclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat ($urandom_range(1, 9)) @(negedge clk);
    limit = (abort_at != 0) ? abort_at : (mode ? 1 : SLAVE_DELAY) + VALID_FRAMES + 2;
    for (int k = 1; k <= limit; k++) begin
      lrclk = 1'b1;
      repeat (5) @(negedge clk);
      chk("R5 busy", int'(mem_busy), exp_busy(k));
      chk(mode ? "R6 valid" : "R7 valid", int'(adc_valid), exp_valid(mode, k));
      if (k == 1) chk("R4 clr once", clr_seen, 1);
      if (k == abort_at) begin
        sys_rst_n = 1'b0;
        lrclk = 1'b0;
        @(negedge clk);
        chk_reset_state("R2");
        break;
      end
      @(negedge clk);
      lrclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    if (abort_at == 0) begin
      chk("R4 clr total", clr_seen, 1);
      chk("R9 gen kept", int'(gen_en), int'(mode));
      chk("R8 valid held", int'(adc_valid), 1);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    sys_rst_n = 1'b0;
    master_mode = 1'b0;
    lrclk = 1'b0;
    repeat (3) @(negedge clk);
    chk_reset_state("R1 power-on");
    rst_n = 1'b1;
    // directed
    trial(1'b1, 0, 1'b0);
    trial(1'b0, 0, 1'b0);
    trial(1'b0, 6, 1'b1);
    trial(1'b1, 4, 1'b0);
    trial(1'b0, 300, 1'b0);
    trial(1'b1, 517, 1'b0);
    // random
    for (int t = 0; t < 4; t++) begin
      bit m = 1'(($urandom() >> 3) & 1);
      int ab = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 400));
      bit lh = 1'(($urandom() >> 5) & 1);
      trial(m, ab, lh);
    end
    finish_run();
  end

endmodule